// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block turns a two-bit operation class from the main control unit and the six-bit function field of an instruction into the four-bit operation select of a 32-bit single-cycle datapath ALU. Loads, stores and branches are resolved from the operation class alone. Register-type instructions take their operation from the function field.

The decoder is purely combinational, with no clock and no reset. Any function code that is not recognised under the register-type class raises an illegal flag. In that case the select output is forced to the AND code, so the datapath never receives an undefined select.

Top module: `alu_op_decoder`

## Requirements
- R1: With op class 2'b00 the select is 4'b0010 (add) and the illegal flag is 0, whatever the function field holds.
- R2: With op class 2'b01 the select is 4'b0110 (subtract) and the illegal flag is 0, whatever the function field holds.
- R3: Bit 0 of the op class takes priority over bit 1, so op class 2'b11 gives the subtract select 4'b0110 with the illegal flag at 0, for any function field.
- R4: With op class 2'b10 the function field is decoded as follows, with the illegal flag at 0:
  - 6'b100100 gives AND, 4'b0000
  - 6'b100101 gives OR, 4'b0001
  - 6'b100000 gives add, 4'b0010
  - 6'b100010 gives subtract, 4'b0110
  - 6'b101010 gives set-less-than, 4'b0111
- R5: With op class 2'b10 and function field 6'b000000, the select is 4'b0000 and the illegal flag is 0.
- R6: With op class 2'b10 and any function value not listed in R4 or R5, the illegal flag is 1 and the select is 4'b0000.
- R7: The illegal flag is never 1 unless the op class is 2'b10.
- R8: The outputs follow a change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class_i | input | 2 | Operation class from main control |
| funct_i | input | 6 | Instruction function field |
| alu_sel_o | output | 4 | ALU operation select |
| illegal_o | output | 1 | Illegal class/function combination |

## Verification
The block holds no state, so a wrong internal value shows only as a wrong select or flag. That error appears at the ports as soon as the inputs settle, in the same step.

A table entry that decodes wrongly appears only for its own function code under op class 2'b10. Because of that, every legal code is driven directly, in addition to the random sweep. A priority error between the class bits appears only with op class 2'b11. A missing fallback appears only with an unlisted function code, so both of these cases are also driven directly.

// File: rtl/alu_op_pkg.sv
package alu_op_pkg;
  localparam int unsigned OP_W    = 2;
  localparam int unsigned FUNCT_W = 6;
  localparam int unsigned SEL_W   = 4;

  localparam logic [SEL_W-1:0] SEL_AND = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_OR  = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_ADD = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_SLT = 4'b0111;

  typedef struct packed {
    logic [FUNCT_W-1:0] funct;
    logic [SEL_W-1:0]   sel;
  } funct_map_t;

  localparam int unsigned N_MAP = 6;

  localparam funct_map_t FUNCT_MAP [N_MAP] = '{
    '{funct: 6'b000000, sel: SEL_AND},
    '{funct: 6'b100100, sel: SEL_AND},
    '{funct: 6'b100101, sel: SEL_OR},
    '{funct: 6'b100000, sel: SEL_ADD},
    '{funct: 6'b100010, sel: SEL_SUB},
    '{funct: 6'b101010, sel: SEL_SLT}
  };
endpackage

// File: rtl/funct_lookup.sv
module funct_lookup
  import alu_op_pkg::*;
(
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               hit_o
);
  logic [N_MAP-1:0] hit;

  for (genvar g = 0; g < N_MAP; g++) begin : g_match
    assign hit[g] = (funct_i == FUNCT_MAP[g].funct);
  end

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_MAP; i++) begin
      if (hit[i]) sel_o = sel_o | FUNCT_MAP[i].sel;
    end
    hit_o = |hit;
  end

  always_comb begin
    assert_single_hit_R4: assert ($onehot0(hit))
      else $error("function table matched more than one entry");
  end
endmodule

// File: rtl/class_select.sv
module class_select
  import alu_op_pkg::*;
(
  input  logic [OP_W-1:0]  op_class_i,
  input  logic [SEL_W-1:0] rtype_sel_i,
  input  logic             rtype_hit_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             illegal_o
);
  always_comb begin
    sel_o     = SEL_ADD;
    illegal_o = 1'b0;
    if (op_class_i[0]) begin
      // Bit 0 wins over bit 1.
      sel_o = SEL_SUB;
    end else if (op_class_i[1]) begin
      sel_o     = rtype_hit_i ? rtype_sel_i : SEL_AND;
      illegal_o = ~rtype_hit_i;
    end
  end
endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_op_pkg::*;
(
  input  logic [OP_W-1:0]    op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [SEL_W-1:0]   alu_sel_o,
  output logic               illegal_o
);
  logic [SEL_W-1:0] rtype_sel;
  logic             rtype_hit;

  funct_lookup u_lookup (
    .funct_i (funct_i),
    .sel_o   (rtype_sel),
    .hit_o   (rtype_hit)
  );

  class_select u_select (
    .op_class_i  (op_class_i),
    .rtype_sel_i (rtype_sel),
    .rtype_hit_i (rtype_hit),
    .sel_o       (alu_sel_o),
    .illegal_o   (illegal_o)
  );

  always_comb begin
    if (op_class_i == 2'b00) begin
      assert_add_class_R1: assert (alu_sel_o == SEL_ADD && !illegal_o)
        else $error("class 00 did not give add");
    end
    if (op_class_i == 2'b01) begin
      assert_sub_class_R2: assert (alu_sel_o == SEL_SUB && !illegal_o)
        else $error("class 01 did not give subtract");
    end
    if (op_class_i == 2'b11) begin
      assert_sub_priority_R3: assert (alu_sel_o == SEL_SUB && !illegal_o)
        else $error("class 11 did not give subtract");
    end
    if (illegal_o) begin
      assert_illegal_zero_R6: assert (alu_sel_o == SEL_AND)
        else $error("illegal flag with nonzero select");
      assert_illegal_scope_R7: assert (op_class_i == 2'b10)
        else $error("illegal flag outside register class");
    end
  end
endmodule

// File: tb/tb_alu_op_decoder.sv
module tb_alu_op_decoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] op_class;
  logic [5:0] funct;
  logic [3:0] sel;
  logic       illegal;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  alu_op_decoder dut (
    .op_class_i (op_class),
    .funct_i    (funct),
    .alu_sel_o  (sel),
    .illegal_o  (illegal)
  );

  function automatic logic [3:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
    if (c[0]) return 4'b0110;
    if (!c[1]) return 4'b0010;
    case (f)
      6'b100000: return 4'b0010;
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b101010: return 4'b0111;
      default:   return 4'b0000;
    endcase
  endfunction

  function automatic logic exp_ill(input logic [1:0] c, input logic [5:0] f);
    if (c != 2'b10) return 1'b0;
    case (f)
      6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010, 6'b000000: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Drive on the falling edge, sample 1 ns later with no rising edge between.
  task automatic apply(input logic [1:0] c, input logic [5:0] f, input string req);
    @(negedge clk);
    op_class = c;
    funct = f;
    #1;
    n_chk++;
    if (sel !== exp_sel(c, f) || illegal !== exp_ill(c, f)) begin
      n_fail++;
      $display("FAIL %s: class=%b funct=%b got sel=%b ill=%b expected sel=%b ill=%b",
               req, c, f, sel, illegal, exp_sel(c, f), exp_ill(c, f));
    end
  endtask

  initial begin
    op_class = 2'b00;
    funct = 6'b0;
    #1;
    n_chk++;
    if (sel !== 4'b0010 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: got sel=%b ill=%b expected sel=0010 ill=0", sel, illegal);
    end
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    apply(2'b00, 6'b101010, "R1");
    apply(2'b00, 6'b111111, "R1");
    apply(2'b01, 6'b100000, "R2");
    apply(2'b01, 6'b010101, "R2");
    apply(2'b11, 6'b100101, "R3");
    apply(2'b11, 6'b111111, "R3");
    apply(2'b10, 6'b100000, "R4");
    apply(2'b10, 6'b100010, "R4");
    apply(2'b10, 6'b100100, "R4");
    apply(2'b10, 6'b100101, "R4");
    apply(2'b10, 6'b101010, "R4");
    apply(2'b10, 6'b000000, "R5");
    apply(2'b10, 6'b100001, "R6");
    apply(2'b10, 6'b111111, "R6");
    apply(2'b10, 6'b000001, "R6");
    apply(2'b01, 6'b000001, "R7");

    // R8: change inputs twice inside one low phase, no clock edge in between.
    @(negedge clk);
    op_class = 2'b10; funct = 6'b100101;
    #0.5;
    n_chk++;
    if (sel !== 4'b0001) begin
      n_fail++;
      $display("FAIL R8: got sel=%b expected sel=0001", sel);
    end
    funct = 6'b101010;
    #0.5;
    n_chk++;
    if (sel !== 4'b0111) begin
      n_fail++;
      $display("FAIL R8: got sel=%b expected sel=0111", sel);
    end

    void'($urandom(32'd5150));
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] c;
      logic [5:0] f;
      c = 2'($urandom());
      f = ($urandom() % 4 == 0) ? 6'b100000 | 6'($urandom() % 11) : 6'($urandom());
      apply(c, f, "R4/R6/R7 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule